// File: doc/BRIEF.md
# I2C Write-Target Receiver

This block is the receive side of a 7-bit-address I2C target. It handles only transfers in which the controller writes to the target. SCL and SDA pass through synchronizers clocked by the system clock. Edge detection on the synchronized lines finds start and stop conditions and the SCL edges. The first byte after a start is compared with a programmable own address. A matching write address is stored and acknowledged. Every data byte that follows is stored and acknowledged in the same way, until a stop or a new start.

Received bytes go into one holding register. Software reads that register with a one-cycle strobe. Status outputs show four things: whether the register holds an unread byte, whether a byte was lost, whether the last stored byte was an address or data, and the latched R/W bit. A per-byte event flag stays set until software clears it. The acknowledge is an open-drain request: while `sda_pull` is high, the pad pulls SDA low.

The controller is an enumerated state machine with these states:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte.
- `ST_DATA`: shifts in a data byte.
- `ST_ACK_SETUP`: waits for SCL to fall after the eighth bit.
- `ST_ACK_HOLD`: drives the acknowledge through the ninth SCL high phase.
- `ST_ACK_DONE`: waits for the ninth clock to fall, then returns to `ST_DATA`.
- `ST_IGNORE`: the address did not match, or R/W was 1; the block waits for the next start.

The transitions are:
- A start condition moves any state to `ST_ADDR`.
- A stop condition moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ACK_SETUP` on the eighth rising SCL edge when the address matches and R/W is 0. On that edge it goes to `ST_IGNORE` otherwise.
- `ST_DATA` goes to `ST_ACK_SETUP` on the eighth rising edge.
- `ST_ACK_SETUP` goes to `ST_ACK_HOLD` on the next SCL fall.
- `ST_ACK_HOLD` goes to `ST_ACK_DONE` on the ninth rising edge.
- `ST_ACK_DONE` goes to `ST_DATA` on the next SCL fall.

Top module: `i2c_wr_target`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and it begins address reception from any state, including in the middle of a transfer (a repeated start). A stop condition is SDA rising while SCL is high, and it returns the block to idle.
- R2: The first byte after a start holds the address in bits 7..1 and R/W in bit 0, and SDA is sampled on each rising SCL edge. If bits 7..1 equal `own_addr` and R/W is 0, the target pulls SDA low on the ninth clock. The whole address byte {own_addr, 0} is then loaded into `rx_data`, and `last_was_data` reads 0.
- R3: On an address mismatch, or when R/W is 1, the target drives no acknowledge. It leaves `rx_data`, `full_flag` and `irq_flag` unchanged and ignores the bus, data bytes included, until the next start.
- R4: After an acknowledged address, each data byte (eight bits, MSB first) is loaded into `rx_data` and acknowledged on the ninth clock, provided the holding register is empty. `last_was_data` then reads 1.
- R5: `full_flag` is set when a byte is loaded and cleared by a one-cycle `buf_rd` strobe.
- R6: If a byte completes while `full_flag` is set, `ovf_flag` is set and no acknowledge is driven for that byte. `rx_data` keeps its old contents.
- R7: `ovf_flag` stays set until a `ovf_clr` strobe.
- R8: `irq_flag` is set for every byte the target accepts from the bus (a matched address or a data byte, overflowed or not). It stays set until a `irq_clr` strobe.
- R9: `sda_pull` changes only while synchronized SCL is low. It rises after the eighth clock falls and falls after the ninth clock falls.
- R10: After reset, `sda_pull`, `full_flag`, `ovf_flag` and `irq_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| own_addr | input | 7 | Programmable own address |
| buf_rd | input | 1 | Read strobe for the holding register; clears full |
| rx_data | output | 8 | Holding register contents |
| full_flag | output | 1 | Holding register holds an unread byte |
| ovf_flag | output | 1 | A byte was lost because the register was full |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| irq_flag | output | 1 | Per-byte event flag |
| irq_clr | input | 1 | Clears `irq_flag` |
| last_was_data | output | 1 | 1 = last stored byte was data, 0 = address |
| rw_bit | output | 1 | R/W bit latched from the last stored address byte |

## Verification
The assertions assume a well-behaved controller:
- SCL stays at each level for several system clocks, more than the synchronizer depth.
- SDA changes only while SCL is low, except at start and stop conditions.
- Software strobes last a single cycle.

The bench drives the bus with eight-cycle SCL phases. It waits two cycles after each SCL fall before changing SDA, and it releases SDA through the ninth clock. It pulses each strobe for exactly one cycle.

// File: rtl/i2c_wr_target_pkg.sv
package i2c_wr_target_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_ACK_DONE,
        ST_IGNORE
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              is_addr;
        logic              rw;
    } rx_byte_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] scl_sr;
    logic [SR_W-1:0] sda_sr;
    logic            scl_prev;
    logic            sda_prev;

    // Idle bus is high: reset the chains to ones so no edge appears at reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[SR_W-2:0], scl_i};
            sda_sr <= {sda_sr[SR_W-2:0], sda_i};
        end
    end

    assign scl_lvl   = scl_sr[SYNC_STAGES-1];
    assign sda_lvl   = sda_sr[SYNC_STAGES-1];
    assign scl_prev  = scl_sr[SYNC_STAGES];
    assign sda_prev  = sda_sr[SYNC_STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_wr_target_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_lvl,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              accept,
    output logic              byte_done,
    output rx_byte_t          byte_out,
    output logic              sda_pull
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

    rx_state_e         state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] sample;
    logic [CNT_W-1:0]  bitcnt;
    logic              ack_ok;
    logic              last_bit;
    logic              addr_hit;

    assign sample   = {shreg[BYTE_W-2:0], sda_lvl};
    assign last_bit = scl_rise && (bitcnt == LAST_CNT);
    assign addr_hit = (sample[BYTE_W-1:1] == own_addr) && !sample[0];

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (last_bit) nxt = addr_hit ? ST_ACK_SETUP : ST_IGNORE;
                ST_DATA:      if (last_bit) nxt = ST_ACK_SETUP;
                ST_ACK_SETUP: if (scl_fall) nxt = ST_ACK_HOLD;
                ST_ACK_HOLD:  if (scl_rise) nxt = ST_ACK_DONE;
                ST_ACK_DONE:  if (scl_fall) nxt = ST_DATA;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shift register, bit counter and latched acknowledge decision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            ack_ok <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
            ack_ok <= 1'b0;
        end else if ((state == ST_ADDR || state == ST_DATA) && scl_rise) begin
            shreg  <= sample;
            bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
            if (byte_done) ack_ok <= accept;
        end
    end

    // Output process.
    always_comb begin
        byte_done        = last_bit && ((state == ST_DATA) || (state == ST_ADDR && addr_hit));
        byte_out.value   = sample;
        byte_out.is_addr = (state == ST_ADDR);
        byte_out.rw      = sample[0];
        sda_pull         = ack_ok && (state == ST_ACK_HOLD || state == ST_ACK_DONE);
    end
endmodule

// File: rtl/i2c_rx_holding.sv
module i2c_rx_holding
    import i2c_wr_target_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  rx_byte_t          byte_in,
    input  logic              buf_rd,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic              accept,
    output logic [BYTE_W-1:0] rx_data,
    output logic              full_flag,
    output logic              ovf_flag,
    output logic              irq_flag,
    output logic              last_was_data,
    output logic              rw_bit
);
    // A read in the same cycle frees the slot for the arriving byte.
    assign accept = !full_flag || buf_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data       <= '0;
            full_flag     <= 1'b0;
            last_was_data <= 1'b0;
            rw_bit        <= 1'b0;
        end else if (byte_done && accept) begin
            rx_data       <= byte_in.value;
            full_flag     <= 1'b1;
            last_was_data <= !byte_in.is_addr;
            if (byte_in.is_addr) rw_bit <= byte_in.rw;
        end else if (buf_rd) begin
            full_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (byte_done && !accept) ovf_flag <= 1'b1;
            else if (ovf_clr)         ovf_flag <= 1'b0;
            if (byte_done)            irq_flag <= 1'b1;
            else if (irq_clr)         irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_target_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              full_flag,
    output logic              ovf_flag,
    input  logic              ovf_clr,
    output logic              irq_flag,
    input  logic              irq_clr,
    output logic              last_was_data,
    output logic              rw_bit
);
    logic     scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic     accept, byte_done;
    rx_byte_t byte_bus;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
        .own_addr(own_addr), .accept(accept), .byte_done(byte_done),
        .byte_out(byte_bus), .sda_pull(sda_pull)
    );

    i2c_rx_holding u_hold (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_in(byte_bus),
        .buf_rd(buf_rd), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
        .accept(accept), .rx_data(rx_data), .full_flag(full_flag),
        .ovf_flag(ovf_flag), .irq_flag(irq_flag),
        .last_was_data(last_was_data), .rw_bit(rw_bit)
    );
endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_pull,
    input logic       byte_done,
    input logic       buf_rd,
    input logic [7:0] rx_data,
    input logic       full_flag,
    input logic       ovf_flag,
    input logic       ovf_clr,
    input logic       irq_flag,
    input logic       irq_clr
);
    // R9
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    // R5
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !byte_done) |=> !full_flag);

    // R6
    full_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && !buf_rd) |=> $stable(rx_data));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind i2c_wr_target i2c_wr_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull),
    .byte_done(byte_done), .buf_rd(buf_rd), .rx_data(rx_data),
    .full_flag(full_flag), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .irq_flag(irq_flag), .irq_clr(irq_clr)
);

// File: tb/test_i2c_wr_target.sv
`timescale 1ns/1ps
module test_i2c_wr_target;
    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h5A;
    localparam logic [7:0] ADDR_WR = {OWN, 1'b0};
    // {pre_read, value, exp_ack, exp_rx_data}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 8'h11, 1'b1, 8'h11},
        {1'b0, 8'h22, 1'b0, 8'h11},
        {1'b1, 8'hA5, 1'b1, 8'hA5},
        {1'b1, 8'h00, 1'b1, 8'h00},
        {1'b1, 8'hFF, 1'b1, 8'hFF},
        {1'b0, 8'h3C, 1'b0, 8'hFF}
    };

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic buf_rd = 0, ovf_clr = 0, irq_clr = 0;
    logic sda_pull, full_flag, ovf_flag, irq_flag, last_was_data, rw_bit;
    logic [7:0] rx_data;
    logic sda_bus;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    assign sda_bus = sda_m & ~sda_pull;
    always #2 clk = ~clk;

    i2c_wr_target i_i2c_wr_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull(sda_pull), .own_addr(OWN), .buf_rd(buf_rd),
        .rx_data(rx_data), .full_flag(full_flag), .ovf_flag(ovf_flag),
        .ovf_clr(ovf_clr), .irq_flag(irq_flag), .irq_clr(irq_clr),
        .last_was_data(last_was_data), .rw_bit(rw_bit)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1; wait_n(Q);
        scl_m = 1; wait_n(Q);
        sda_m = 0; wait_n(Q);
        scl_m = 0; wait_n(2);
    endtask

    task automatic bus_stop;
        sda_m = 0; wait_n(Q);
        scl_m = 1; wait_n(Q);
        sda_m = 1; wait_n(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(Q);
            scl_m = 1;    wait_n(Q);
            scl_m = 0;    wait_n(2);
        end
        sda_m = 1; wait_n(Q);
        scl_m = 1; wait_n(Q/2);
        acked = ~sda_bus; wait_n(Q/2);
        scl_m = 0; wait_n(Q);
    endtask

    task automatic pulse_rd;  buf_rd = 1;  wait_n(1); buf_rd = 0;  wait_n(1); endtask
    task automatic pulse_ovf; ovf_clr = 1; wait_n(1); ovf_clr = 0; wait_n(1); endtask
    task automatic pulse_irq; irq_clr = 1; wait_n(1); irq_clr = 0; wait_n(1); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack;
        wait_n(4); rst_n = 1; wait_n(4);
        // R10 reset state
        check("R10 pull", sda_pull, 0);
        check("R10 full", full_flag, 0);
        check("R10 ovf", ovf_flag, 0);
        check("R10 irq", irq_flag, 0);

        // R2 matched write address
        bus_start;
        send_byte(ADDR_WR, ack);
        check("R2 ack", ack, 1);
        check("R2 rx_data", rx_data, ADDR_WR);
        check("R2 last_was_data", last_was_data, 0);
        check("R2 rw_bit", rw_bit, 0);
        check("R5 full set", full_flag, 1);
        check("R8 irq set", irq_flag, 1);
        pulse_rd;
        check("R5 full cleared", full_flag, 0);
        pulse_irq;
        check("R8 irq cleared", irq_flag, 0);

        // R4 / R6 vector table
        foreach (VEC[k]) begin
            if (VEC[k][17]) pulse_rd;
            send_byte(VEC[k][16:9], ack);
            check(VEC[k][8] ? "R4 ack" : "R6 no ack", ack, VEC[k][8]);
            check(VEC[k][8] ? "R4 rx_data" : "R6 rx_data kept", rx_data, VEC[k][7:0]);
            check("R8 irq per byte", irq_flag, 1);
            pulse_irq;
        end
        check("R4 last_was_data", last_was_data, 1);
        check("R6 ovf set", ovf_flag, 1);
        // R7 sticky until cleared
        pulse_rd;
        wait_n(20);
        check("R7 ovf held", ovf_flag, 1);
        pulse_ovf;
        check("R7 ovf cleared", ovf_flag, 0);

        // R1 stop returns to idle
        bus_stop;
        check("R1 pull after stop", sda_pull, 0);

        // R3 mismatched address, then a data byte that must be ignored
        bus_start;
        send_byte(8'h66, ack);
        check("R3 mismatch no ack", ack, 0);
        send_byte(8'h99, ack);
        check("R3 data ignored ack", ack, 0);
        check("R3 full unchanged", full_flag, 0);
        check("R3 irq unchanged", irq_flag, 0);
        bus_stop;
        // R3 read request (R/W=1) to own address
        bus_start;
        send_byte({OWN, 1'b1}, ack);
        check("R3 rw1 no ack", ack, 0);
        check("R3 rw1 irq", irq_flag, 0);
        check("R3 rw1 rx_data", rx_data, 8'hFF);
        bus_stop;

        // R1 repeated start
        bus_start;
        send_byte(ADDR_WR, ack);
        pulse_rd;
        send_byte(8'h77, ack);
        check("R4 ack 77", ack, 1);
        pulse_rd;
        bus_start;
        send_byte(ADDR_WR, ack);
        check("R1 restart ack", ack, 1);
        check("R1 restart rx_data", rx_data, ADDR_WR);
        check("R1 restart last_was_data", last_was_data, 0);
        pulse_rd;
        send_byte(8'h42, ack);
        check("R4 rx 42", rx_data, 8'h42);
        check("R4 data flag", last_was_data, 1);
        bus_stop;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule